// File: doc/BRIEF.md
# Maskable Interrupt Controller with Read-Clear Flags

This block gathers interrupt events from a small processor's surroundings and turns them into one request line for the CPU. There are two kinds of source. The first kind is a set of external pins. Each pin passes through a synchronizer and then an edge detector, and a control bit chooses whether that pin reacts to a rising or a falling edge. The second kind is a set of internal event lines driven by on-chip peripherals such as counters, the prescaler, the supply detector and the serial port. Each event, of either kind, sets a sticky flag.

Software reaches the block through a narrow register port with a 4-bit data path. The flags are packed into 4-bit registers, and so are the per-source enables. A read of a flag register returns the flags and clears exactly the flags it returned. A write to a flag register clears the flags at the positions written with 1. A single control register holds the general request enable and the edge polarity bits.

The CPU request goes high when the general enable is set and at least one flag is pending with its enable bit set. When the CPU executes a halt, it pulses a strobe into the block, and that strobe turns the general enable on. A pending, enabled source can then end standby through the request line.

Top module: `irq_hub`

## Requirements
- R1: After reset every flag is 0, every enable bit is 0, the general enable is 0, every polarity bit is 0 and `irq_req` is 0.
- R2: A high level on `int_pulse[k]` in a cycle sets flag k+2 at the next clock edge. The flag then stays set until software clears it. Flag bits 3:0 read at address 0 and flag bits 7:4 read at address 1.
- R3: For each external pin p, the flag p is set exactly SYNC_STAGES+1 clock edges after the pin changes in the selected direction. Control bit p+1 selects the direction: 0 means rising and 1 means falling. A change in the other direction sets no flag.
- R4: A read of flag address 0 or 1 returns that register's flags and clears them at the clock edge. The other flag register is left unchanged.
- R5: A write to flag address 0 or 1 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R6: A source event in the same cycle as a clearing read or a clearing write of its flag leaves the flag set.
- R7: Enable bits are at address 2 (sources 3:0) and address 3 (sources 7:4), with 1 meaning enabled. A source whose enable bit is 0 still sets its flag.
- R8: `irq_req` is 1 exactly when control bit 0 (the general enable) is 1 and some flag is set whose enable bit is 1.
- R9: Address 4 is the control register: bit 0 is the general enable, and bits 2:1 are the polarity bits of pins 1:0. It reads back as written, with bit 3 reading 0.
- R10: A `halt_enter` pulse sets the general enable at the next edge. This holds even when a write to the control register clears that bit in the same cycle.
- R11: Addresses 5 to 7 read as 0, and writes to them change no register.
- R12: Reads of addresses 2, 3 and 4 do not change any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | N_EXT (2) | External interrupt pins, asynchronous |
| int_pulse | input | N_INT (6) | Internal event lines; a high cycle is one event |
| halt_enter | input | 1 | One-cycle strobe when the CPU enters halt |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears the flags it returns) |
| reg_wdata | input | BUS_W (4) | Write data |
| reg_rdata | output | BUS_W (4) | Read data, combinational from `reg_addr` |
| irq_req | output | 1 | General interrupt request to the CPU |

## Verification
The embedded properties assume that the register strobes and internal event lines are synchronous to `clk`. They also assume that the polarity selection stays fixed while an edge is in flight, because the single-edge property allows for a polarity change. The bench changes every input half a period away from the active edge. It holds the external pins low through reset and changes the polarity bits only while the synchronized pin is steady. This keeps the stimulus within those assumptions while it sweeps all internal event patterns and all 256 enable settings.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Decoded meaning of a register address.
   typedef enum logic [1:0] {
      KIND_FLAG = 2'd0,
      KIND_MASK = 2'd1,
      KIND_CTRL = 2'd2,
      KIND_NONE = 2'd3
   } reg_kind_e;

   // Number of data-bus-wide registers needed to hold a given number of bits.
   function automatic int banks_for(input int bits, input int bus_w);
      return (bits + bus_w - 1) / bus_w;
   endfunction

   // Number of live bits in bank b.
   function automatic int live_in_bank(input int bits, input int bus_w, input int b);
      int rem;
      rem = bits - b * bus_w;
      return (rem > bus_w) ? bus_w : rem;
   endfunction

endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic evt
);

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("irqc_edge_det: SYNC_STAGES must not be negative");
   end

   logic synced;
   logic prev;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = pin;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] shreg;
      always_ff @(posedge clk) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= SYNC_STAGES'({shreg, pin});
      end
      assign synced = shreg[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= synced;
   end

   assign evt = fall_sel ? (prev & ~synced) : (~prev & synced);

   // With the polarity held, two edges of the same direction cannot follow back to back.
   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (!evt || (fall_sel != $past(fall_sel)))); // R3

endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
   parameter int BUS_W      = 4,
   parameter int VALID_BITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] set_evt,
   input  logic             rd_flag,
   input  logic             wr_flag,
   input  logic             wr_mask,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] flags,
   output logic [BUS_W-1:0] mask
);

   if (VALID_BITS < 1 || VALID_BITS > BUS_W) begin : g_bad_valid
      $error("irqc_flag_bank: VALID_BITS out of range");
   end

   function automatic logic [BUS_W-1:0] live_bits();
      logic [BUS_W-1:0] v;
      v = '0;
      for (int i = 0; i < BUS_W; i++) begin
         if (i < VALID_BITS) v[i] = 1'b1;
      end
      return v;
   endfunction

   localparam logic [BUS_W-1:0] LIVE = live_bits();

   logic [BUS_W-1:0] clr;

   always_comb begin
      clr = '0;
      if (rd_flag) clr = clr | flags;
      if (wr_flag) clr = clr | wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= '0;
      end else begin
         flags <= (set_evt | (flags & ~clr)) & LIVE;
         if (wr_mask) mask <= wdata & LIVE;
      end
   end

   AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_evt & LIVE) != '0) |=> ((flags & $past(set_evt & LIVE)) == $past(set_evt & LIVE))); // R6

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flag && !wr_flag && set_evt == '0) |=> (flags == '0)); // R4

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && !rd_flag) |=> ((flags & $past(wdata & ~set_evt)) == '0)); // R5

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(mask)); // R12

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
   parameter int BUS_W = 4,
   parameter int N_EXT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic [BUS_W-1:0] wdata,
   input  logic             halt_enter,
   output logic             gen_en,
   output logic [N_EXT-1:0] fall_sel,
   output logic [BUS_W-1:0] ctrl_rd
);

   if (N_EXT + 1 > BUS_W) begin : g_bad_ctrl
      $error("irqc_ctrl: control register cannot hold enable and polarity bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_en   <= 1'b0;
         fall_sel <= '0;
      end else begin
         if (wr_ctrl) begin
            gen_en   <= wdata[0];
            fall_sel <= wdata[N_EXT:1];
         end
         if (halt_enter) gen_en <= 1'b1;
      end
   end

   assign ctrl_rd = BUS_W'({fall_sel, gen_en});

   AST_HALT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      halt_enter |=> gen_en); // R10

   AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctrl && !halt_enter) |=> ($stable(gen_en) && $stable(fall_sel))); // R12

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irqc_pkg::*;
#(
   parameter int N_EXT       = 2,
   parameter int N_INT       = 6,
   parameter int BUS_W       = 4,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EXT-1:0]  ext_pin,
   input  logic [N_INT-1:0]  int_pulse,
   input  logic              halt_enter,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              irq_req
);

   localparam int N_SRC     = N_EXT + N_INT;
   localparam int N_BANK    = banks_for(N_SRC, BUS_W);
   localparam int FLAT      = N_BANK * BUS_W;
   localparam int ADDR_CTRL = 2 * N_BANK;

   if (N_EXT < 1 || N_INT < 0) begin : g_bad_src
      $error("irq_hub: need at least one external source");
   end
   if (ADDR_CTRL + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_hub: ADDR_W too small for the register map");
   end

   logic [N_EXT-1:0]              ext_evt;
   logic [FLAT-1:0]               src_evt;
   logic [N_BANK-1:0][BUS_W-1:0]  bank_flags;
   logic [N_BANK-1:0][BUS_W-1:0]  bank_mask;
   logic                          gen_en;
   logic [N_EXT-1:0]              fall_sel;
   logic [BUS_W-1:0]              ctrl_rd;
   logic                          wr_ctrl;
   reg_kind_e                     kind;

   for (genvar p = 0; p < N_EXT; p++) begin : g_pin
      irqc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (ext_pin[p]),
         .fall_sel (fall_sel[p]),
         .evt      (ext_evt[p])
      );
   end

   assign src_evt = FLAT'({int_pulse, ext_evt});

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      logic sel_flag;
      logic sel_mask;
      assign sel_flag = (reg_addr == ADDR_W'(b));
      assign sel_mask = (reg_addr == ADDR_W'(N_BANK + b));
      irqc_flag_bank #(
         .BUS_W      (BUS_W),
         .VALID_BITS (live_in_bank(N_SRC, BUS_W, b))
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (src_evt[b*BUS_W +: BUS_W]),
         .rd_flag (reg_rd && sel_flag),
         .wr_flag (reg_wr && sel_flag),
         .wr_mask (reg_wr && sel_mask),
         .wdata   (reg_wdata),
         .flags   (bank_flags[b]),
         .mask    (bank_mask[b])
      );
   end

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));

   irqc_ctrl #(.BUS_W(BUS_W), .N_EXT(N_EXT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl),
      .wdata      (reg_wdata),
      .halt_enter (halt_enter),
      .gen_en     (gen_en),
      .fall_sel   (fall_sel),
      .ctrl_rd    (ctrl_rd)
   );

   always_comb begin
      kind      = KIND_NONE;
      reg_rdata = '0;
      for (int b = 0; b < N_BANK; b++) begin
         if (reg_addr == ADDR_W'(b)) begin
            kind      = KIND_FLAG;
            reg_rdata = bank_flags[b];
         end
         if (reg_addr == ADDR_W'(N_BANK + b)) begin
            kind      = KIND_MASK;
            reg_rdata = bank_mask[b];
         end
      end
      if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
         kind      = KIND_CTRL;
         reg_rdata = ctrl_rd;
      end
   end

   assign irq_req = gen_en & (|(bank_flags & bank_mask));

   AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> !irq_req); // R8

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == KIND_NONE) |-> (reg_rdata == '0)); // R11

endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_pin = '0;
   logic [5:0] int_pulse = '0;
   logic       halt_enter = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       irq_req;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_hub u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_pulse(int_pulse),
      .halt_enter(halt_enter), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [3:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [3:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [5:0] p);
      @(negedge clk);
      int_pulse = p;
      @(negedge clk);
      int_pulse = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [3:0] d;
      logic [7:0] f_all;
      logic [5:0] f;
      logic       exp_req;

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      check("R1 irq_req", {7'd0, irq_req}, 8'd0);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 register", {4'd0, d}, 8'd0);
      end

      // R2 / R4: every internal event pattern
      for (int p = 0; p < 64; p++) begin
         pulse(6'(p));
         f_all = {6'(p), 2'b00};
         rd(3'd0, d); check("R2 low flags", {4'd0, d}, {4'd0, f_all[3:0]});
         rd(3'd1, d); check("R2 R4 high flags kept", {4'd0, d}, {4'd0, f_all[7:4]});
         rd(3'd0, d); check("R4 low cleared", {4'd0, d}, 8'd0);
         rd(3'd1, d); check("R4 high cleared", {4'd0, d}, 8'd0);
      end

      // R7 / R8: all enable settings
      for (int m = 0; m < 256; m++) begin
         f = 6'((m * 37 + 11) & 63);
         f_all = {f, 2'b00};
         wr(3'd2, 4'(m));
         wr(3'd3, 4'(m >> 4));
         wr(3'd4, 4'b0001);
         pulse(f);
         exp_req = |(f_all & 8'(m));
         check("R8 request", {7'd0, irq_req}, {7'd0, exp_req});
         wr(3'd4, 4'b0000);
         check("R8 disabled", {7'd0, irq_req}, 8'd0);
         rd(3'd2, d); check("R7 R12 mask low", {4'd0, d}, {4'd0, 4'(m)});
         rd(3'd0, d); check("R7 low flags", {4'd0, d}, {4'd0, f_all[3:0]});
         rd(3'd1, d); check("R7 high flags", {4'd0, d}, {4'd0, f_all[7:4]});
      end

      // R5: write clears selected flags only
      pulse(6'h3F);
      wr(3'd0, 4'b0100);
      rd(3'd0, d); check("R5 low write-clear", {4'd0, d}, 8'h08);
      wr(3'd1, 4'b0101);
      rd(3'd1, d); check("R5 high write-clear", {4'd0, d}, 8'h0A);

      // R6: event coincident with clearing read
      pulse(6'b000001);
      @(negedge clk);
      reg_addr = 3'd0; reg_rd = 1'b1; int_pulse = 6'b000001;
      #1 d = reg_rdata;
      check("R6 read value", {4'd0, d}, 8'h04);
      @(negedge clk);
      reg_rd = 1'b0; int_pulse = '0;
      rd(3'd0, d); check("R6 read keeps flag", {4'd0, d}, 8'h04);
      // R6: event coincident with clearing write
      pulse(6'b000010);
      @(negedge clk);
      reg_addr = 3'd0; reg_wdata = 4'b1000; reg_wr = 1'b1; int_pulse = 6'b000010;
      @(negedge clk);
      reg_wr = 1'b0; int_pulse = '0;
      rd(3'd0, d); check("R6 write keeps flag", {4'd0, d}, 8'h08);

      // R3: external edges, latency SYNC_STAGES+1 = 3 edges
      wr(3'd2, 4'b0011);
      wr(3'd3, 4'b0000);
      wr(3'd4, 4'b0001);
      @(negedge clk); ext_pin[0] = 1'b1;
      @(negedge clk); check("R3 latency edge1", {7'd0, irq_req}, 8'd0);
      @(negedge clk); check("R3 latency edge2", {7'd0, irq_req}, 8'd0);
      @(negedge clk); check("R3 latency edge3", {7'd0, irq_req}, 8'd1);
      rd(3'd0, d); check("R3 rising pin0", {4'd0, d}, 8'h01);
      @(negedge clk); ext_pin[0] = 1'b0;
      idle(5);
      check("R3 falling ignored", {7'd0, irq_req}, 8'd0);
      wr(3'd4, 4'b0011);
      @(negedge clk); ext_pin[0] = 1'b1;
      idle(5);
      check("R3 rising ignored when falling selected", {7'd0, irq_req}, 8'd0);
      @(negedge clk); ext_pin[0] = 1'b0;
      idle(5);
      check("R3 falling pin0", {7'd0, irq_req}, 8'd1);
      rd(3'd0, d); check("R3 falling flag", {4'd0, d}, 8'h01);
      @(negedge clk); ext_pin[1] = 1'b1;
      idle(5);
      rd(3'd0, d); check("R3 rising pin1", {4'd0, d}, 8'h02);

      // R9: control readback
      wr(3'd4, 4'b0110);
      rd(3'd4, d); check("R9 control readback", {4'd0, d}, 8'h06);

      // R10: halt strobe
      @(negedge clk); halt_enter = 1'b1;
      @(negedge clk); halt_enter = 1'b0;
      rd(3'd4, d); check("R10 halt sets enable", {4'd0, d}, 8'h07);
      @(negedge clk);
      reg_addr = 3'd4; reg_wdata = 4'b0000; reg_wr = 1'b1; halt_enter = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; halt_enter = 1'b0;
      rd(3'd4, d); check("R10 halt wins over write", {4'd0, d}, 8'h01);

      // R11: unmapped addresses
      wr(3'd2, 4'b1010);
      for (int a = 5; a < 8; a++) begin
         wr(3'(a), 4'hF);
         rd(3'(a), d); check("R11 unmapped reads 0", {4'd0, d}, 8'd0);
      end
      rd(3'd2, d); check("R11 mask untouched", {4'd0, d}, 8'h0A);
      rd(3'd4, d); check("R11 R12 control untouched", {4'd0, d}, 8'h01);
      rd(3'd0, d); check("R11 flags untouched", {4'd0, d}, 8'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule